// File: doc/BRIEF.md
# Operate Unit with Condition Flags

This block carries out the three data-manipulating instructions of a 16-bit word-addressed load/store processor: two's complement add, bitwise AND and bitwise NOT. The surrounding pipeline presents an instruction word with a valid strobe, together with the contents of the two source registers it has already read from an eight-entry register file. One cycle later the block returns a write request for the register file: the destination index, the result and a write enable.

The block keeps the three sign flags (negative, zero, positive) in a small status register. Every instruction it completes updates these flags, and exactly one flag is set at any time. For add and AND, the second operand is either a register or a 5-bit immediate. An instruction bit selects which one, and the immediate is sign-extended to the datapath width.

Opcodes outside the operate group and malformed operate encodings are not executed. For these the block raises a one-cycle illegal pulse. It does not write a register and it leaves the flags unchanged.

Top module: `opu_core`

## Requirements
- R1: The opcode is instr[15:12]. 4'b0001 is add, 4'b0101 is AND and 4'b1001 is NOT. A valid instruction with any other opcode produces illegal=1 and wr_en=0.
- R2: The destination index is instr[11:9] and is returned on wr_idx. src_a carries the register named by instr[8:6], and src_b carries the register named by instr[2:0].
- R3: For add and AND, instr[5]=1 selects immediate mode. The second operand is then instr[4:0] sign-extended to 16 bits, and src_b has no effect on the result.
- R4: For add and AND with instr[5]=0, the second operand is src_b. If instr[4:3] is not 2'b00, the instruction is illegal and nothing is written.
- R5: NOT returns ~src_a. Unless instr[5:0] is 6'b111111, the instruction is illegal and nothing is written.
- R6: Add is modulo 2^16, and a carry out of bit 15 is dropped.
- R7: After each register write, exactly one flag is set. flag_n is set when result bit 15 is 1, flag_z when the result is zero, and flag_p otherwise.
- R8: The flags keep their value in any cycle with no write, including cycles after an illegal instruction.
- R9: After reset, flag_z=1, flag_n=0, flag_p=0, wr_en=0, illegal=0, wr_idx=0 and wr_data=0.
- R10: wr_en and illegal are registered. They appear in the cycle after the valid strobe and last one cycle per strobe, so back-to-back strobes give back-to-back results. Without a strobe neither rises.
- R11: An AND with immediate 0 writes 16'h0000 and sets flag_z, whatever the value of src_a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | First source register value (instr[8:6]) |
| src_b | input | 16 | Second source register value (instr[2:0]) |
| wr_en | output | 1 | Register file write enable |
| wr_idx | output | 3 | Destination register index |
| wr_data | output | 16 | Result to write |
| illegal | output | 1 | Instruction not executable by this unit |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
The bench builds the block with its default width of 16 bits and an immediate field of 5 bits. At these values, the bit-15 sign boundary (16'h7FFF + 1) and the wrap of 16'hFFFF + 1 can be reached directly with operands. The immediate values -1 and 0 exercise full-width sign extension, including the masking case where AND with immediate 0 clears the destination. Malformed NOT and register-mode encodings, together with a foreign opcode, show that flags and write enable stay put. A run of back-to-back strobes exercises the one-cycle pulse timing.

// File: rtl/opu_pkg.sv
package opu_pkg;

  localparam int INSTR_W = 16;
  localparam int IDX_W   = 3;
  localparam int IMM_W   = 5;

  // operate-group opcodes (instr[15:12])
  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_AND = 2'd1,
    FN_NOT = 2'd2
  } alu_fn_e;

  typedef struct packed {
    logic              legal;
    alu_fn_e           fn;
    logic              use_imm;
    logic [IDX_W-1:0]  dst;
    logic [IMM_W-1:0]  imm;
  } dec_t;

endpackage

// File: rtl/opu_decode.sv
module opu_decode
  import opu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  localparam int OPC_LSB  = 12;
  localparam int DST_LSB  = 9;
  localparam int MODE_BIT = 5;

  logic [3:0] opc;
  logic       mode_imm;
  logic       reg_pad_ok;
  logic       not_tail_ok;

  assign opc         = instr[OPC_LSB +: 4];
  assign mode_imm    = instr[MODE_BIT];
  assign reg_pad_ok  = (instr[4:3] == 2'b00);
  assign not_tail_ok = (instr[5:0] == 6'b111111);

  always_comb begin
    dec         = '0;
    dec.dst     = instr[DST_LSB +: IDX_W];
    dec.imm     = instr[IMM_W-1:0];
    dec.use_imm = 1'b0;
    dec.fn      = FN_ADD;
    dec.legal   = 1'b0;
    unique case (opc)
      OPC_ADD: begin
        dec.fn      = FN_ADD;
        dec.use_imm = mode_imm;
        dec.legal   = mode_imm || reg_pad_ok;
      end
      OPC_AND: begin
        dec.fn      = FN_AND;
        dec.use_imm = mode_imm;
        dec.legal   = mode_imm || reg_pad_ok;
      end
      OPC_NOT: begin
        dec.fn      = FN_NOT;
        dec.legal   = not_tail_ok;
      end
      default: begin
        dec.legal   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/opu_alu.sv
module opu_alu
  import opu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] sum_v;
  logic [DATA_W-1:0] and_v;
  logic [DATA_W-1:0] inv_v;

  // carry out is dropped by truncation to DATA_W
  assign sum_v = opa + opb;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    assign and_v[gi] = opa[gi] & opb[gi];
    assign inv_v[gi] = ~opa[gi];
  end

  always_comb begin
    unique case (fn)
      FN_ADD:  res = sum_v;
      FN_AND:  res = and_v;
      FN_NOT:  res = inv_v;
      default: res = sum_v;
    endcase
  end

endmodule

// File: rtl/opu_flags.sv
module opu_flags #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] res,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);

  logic [2:0] nzp_q;
  logic [2:0] nzp_d;
  logic       is_neg;
  logic       is_zero;

  assign is_neg  = res[DATA_W-1];
  assign is_zero = (res == '0);

  always_comb begin
    nzp_d = nzp_q;
    if (upd) begin
      nzp_d = {is_neg, is_zero, !is_neg && !is_zero};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzp_q <= 3'b010;
    end else begin
      nzp_q <= nzp_d;
    end
  end

  assign flag_n = nzp_q[2];
  assign flag_z = nzp_q[1];
  assign flag_p = nzp_q[0];

  p_one_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_n, flag_z, flag_p}) == 1);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({flag_n, flag_z, flag_p}));

  p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flag_n == $past(res[DATA_W-1])));

endmodule

// File: rtl/opu_core.sv
module opu_core
  import opu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DATA_W-1:0]   src_a,
  input  logic [DATA_W-1:0]   src_b,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [DATA_W-1:0]   wr_data,
  output logic                illegal,
  output logic                flag_n,
  output logic                flag_z,
  output logic                flag_p
);

  localparam int EXT_W = DATA_W - IMM_W;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dec_t              dec;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] alu_res;
  logic              do_write;

  opu_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign imm_ext  = {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm};
  assign opb      = dec.use_imm ? imm_ext : src_b;
  assign do_write = in_valid && dec.legal;

  opu_alu #(.DATA_W(DATA_W)) u_alu (
    .fn  (dec.fn),
    .opa (src_a),
    .opb (opb),
    .res (alu_res)
  );

  opu_flags #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .upd    (do_write),
    .res    (alu_res),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_p (flag_p)
  );

  // output register: next state
  logic              we_d, we_q;
  logic              ill_d, ill_q;
  logic [IDX_W-1:0]  idx_d, idx_q;
  logic [DATA_W-1:0] dat_d, dat_q;

  always_comb begin
    we_d  = do_write;
    ill_d = in_valid && !dec.legal;
    idx_d = idx_q;
    dat_d = dat_q;
    if (do_write) begin
      idx_d = dec.dst;
      dat_d = alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      we_q  <= 1'b0;
      ill_q <= 1'b0;
      idx_q <= '0;
      dat_q <= '0;
    end else begin
      we_q  <= we_d;
      ill_q <= ill_d;
      idx_q <= idx_d;
      dat_q <= dat_d;
    end
  end

  assign wr_en   = we_q;
  assign illegal = ill_q;
  assign wr_idx  = idx_q;
  assign wr_data = dat_q;

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && illegal));

  p_we_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en || illegal) |-> $past(in_valid));

  p_dst_field_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (wr_idx == $past(instr[11:9])));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (flag_z == (wr_data == '0)));

  p_not_tail_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && instr[15:12] == OPC_NOT && instr[5:0] != 6'h3F) |=> (illegal && !wr_en));

  p_reg_pad_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !instr[5] && instr[4:3] != 2'b00) |=> !wr_en);

endmodule

// File: tb/opu_core_test.sv
module opu_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] instr;
  logic [15:0] src_a;
  logic [15:0] src_b;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data;
  logic        illegal;
  logic        flag_n, flag_z, flag_p;

  int checks = 0;
  int errors = 0;
  logic en_x, ez_x, ep_x;   // expected flags tracked by the bench
  logic [2:0]  eidx_x;
  logic [15:0] edat_x;

  always #10 clk = ~clk;   // 50 MHz

  opu_core uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .illegal(illegal), .flag_n(flag_n),
    .flag_z(flag_z), .flag_p(flag_p)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] e_add_r(input logic [2:0] d, s1, s2);
    return {4'b0001, d, s1, 3'b000, s2};
  endfunction
  function automatic logic [15:0] e_imm(input logic [3:0] op, input logic [2:0] d, s1,
                                        input logic [4:0] imm);
    return {op, d, s1, 1'b1, imm};
  endfunction
  function automatic logic [15:0] e_and_r(input logic [2:0] d, s1, s2);
    return {4'b0101, d, s1, 3'b000, s2};
  endfunction
  function automatic logic [15:0] e_not(input logic [2:0] d, s1);
    return {4'b1001, d, s1, 6'h3F};
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [15:0] ins, a, b,
                       output logic legal, output logic [15:0] res);
    logic [15:0] op2;
    op2   = ins[5] ? {{11{ins[4]}}, ins[4:0]} : b;
    legal = 1'b0;
    res   = 16'h0;
    case (ins[15:12])
      4'b0001: begin legal = ins[5] || (ins[4:3] == 2'b00); res = a + op2; end
      4'b0101: begin legal = ins[5] || (ins[4:3] == 2'b00); res = a & op2; end
      4'b1001: begin legal = (ins[5:0] == 6'h3F);           res = ~a;      end
      default: legal = 1'b0;
    endcase
  endtask

  task automatic chk_flags(input string req);
    chk(req, "flags", {13'h0, flag_n, flag_z, flag_p}, {13'h0, en_x, ez_x, ep_x});
  endtask

  // one strobe; result checked the cycle after, pulse end checked after that
  task automatic run_op(input string req, input logic [15:0] ins, a, b);
    logic legal;
    logic [15:0] res;
    model(ins, a, b, legal, res);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0; src_b = ~b; instr = 16'h0000;
    if (legal) begin
      en_x = res[15]; ez_x = (res == 16'h0); ep_x = !res[15] && (res != 16'h0);
      eidx_x = ins[11:9]; edat_x = res;
    end
    chk(req, "wr_en", {15'h0, wr_en}, {15'h0, legal});
    chk(req, "illegal", {15'h0, illegal}, {15'h0, !legal});
    chk(req, "wr_idx", {13'h0, wr_idx}, {13'h0, eidx_x});
    chk(req, "wr_data", wr_data, edat_x);
    chk_flags(req);
    @(negedge clk);
    chk("R10", "pulse end", {14'h0, wr_en, illegal}, 16'h0);
  endtask

  task automatic t_reset();
    chk("R9", "wr_en", {15'h0, wr_en}, 16'h0);
    chk("R9", "illegal", {15'h0, illegal}, 16'h0);
    chk("R9", "wr_idx", {13'h0, wr_idx}, 16'h0);
    chk("R9", "wr_data", wr_data, 16'h0);
    chk_flags("R9");
  endtask

  task automatic t_add();
    run_op("R2", e_add_r(3'd1, 3'd4, 3'd5), 16'h0012, 16'h0034);
    run_op("R6", e_add_r(3'd7, 3'd0, 3'd1), 16'hFFFF, 16'h0001);
    run_op("R7", e_add_r(3'd2, 3'd3, 3'd3), 16'h7FFF, 16'h0001);
    run_op("R3", e_imm(4'b0001, 3'd5, 3'd1, 5'b11110), 16'h0005, 16'hABCD);
    run_op("R3", e_imm(4'b0001, 3'd6, 3'd2, 5'b01111), 16'h0001, 16'h8000);
  endtask

  task automatic t_and();
    run_op("R4", e_and_r(3'd2, 3'd3, 3'd6), 16'hF0F0, 16'h3C3C);
    run_op("R11", e_imm(4'b0101, 3'd2, 3'd2, 5'b00000), 16'hBEEF, 16'hFFFF);
    run_op("R3", e_imm(4'b0101, 3'd4, 3'd1, 5'b11111), 16'h9A5C, 16'h0000);
  endtask

  task automatic t_not();
    run_op("R5", e_not(3'd3, 3'd5), 16'h00FF, 16'h1234);
    run_op("R5", e_not(3'd0, 3'd7), 16'hFFFF, 16'h0000);
  endtask

  task automatic t_illegal();
    run_op("R7", e_imm(4'b0001, 3'd1, 3'd1, 5'b00011), 16'h0004, 16'h0);
    run_op("R1", {4'b0010, 3'd1, 9'h010}, 16'h0000, 16'h0000);
    run_op("R1", {4'b1101, 12'h000}, 16'hFFFF, 16'hFFFF);
    run_op("R4", {4'b0001, 3'd2, 3'd1, 3'b001, 3'd3}, 16'h8000, 16'h8000);
    run_op("R4", {4'b0101, 3'd2, 3'd1, 3'b010, 3'd3}, 16'h0000, 16'h0000);
    run_op("R5", {4'b1001, 3'd2, 3'd1, 6'h3E}, 16'h0000, 16'h0000);
    chk_flags("R8");
  endtask

  task automatic t_no_valid();
    @(negedge clk);
    in_valid = 1'b0; instr = e_add_r(3'd1, 3'd1, 3'd1); src_a = 16'h0; src_b = 16'h0;
    @(negedge clk);
    chk("R10", "no strobe wr_en", {15'h0, wr_en}, 16'h0);
    chk("R8", "no strobe data", wr_data, edat_x);
    chk_flags("R8");
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    in_valid = 1'b1; instr = e_imm(4'b0001, 3'd1, 3'd0, 5'b00001); src_a = 16'h0001; src_b = 16'h0;
    @(negedge clk);
    instr = e_imm(4'b0001, 3'd2, 3'd0, 5'b11111); src_a = 16'h0000;
    chk("R10", "b2b first we", {15'h0, wr_en}, 16'h1);
    chk("R10", "b2b first data", wr_data, 16'h0002);
    chk("R10", "b2b first idx", {13'h0, wr_idx}, 16'h1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "b2b second we", {15'h0, wr_en}, 16'h1);
    chk("R10", "b2b second data", wr_data, 16'hFFFF);
    chk("R10", "b2b second idx", {13'h0, wr_idx}, 16'h2);
    en_x = 1'b1; ez_x = 1'b0; ep_x = 1'b0; edat_x = 16'hFFFF; eidx_x = 3'd2;
    chk_flags("R7");
    @(negedge clk);
    chk("R10", "b2b end", {15'h0, wr_en}, 16'h0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = 16'h0; src_a = 16'h0; src_b = 16'h0;
    en_x = 1'b0; ez_x = 1'b1; ep_x = 1'b0; eidx_x = 3'd0; edat_x = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add();
    t_and();
    t_not();
    t_illegal();
    t_no_valid();
    t_back_to_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule